// File: doc/BRIEF.md
# Electronic Shutter Timing Generator

This block sets the effective charge storage time of an interline image sensor. It counts the lines of each field from the vertical sync and issues a one-line read pulse at the start of every field. It empties the photosites through the substrate drain in the lines before the programmed storage window, so the charge that is kept builds up only during the last N lines before the next read. The substrate bias is raised to its discard level only inside horizontal blanking, which keeps switching noise out of the active picture. Each blanking interval carries a short burst of pulses rather than one long one, so the discard is spread over many small pulses.

The storage time is programmed in whole line periods, from one line up to a full field. The setting is sampled once per field, at the vertical sync that starts the read line. The field length alternates between two counts (312 and 313 lines by default) to give a field of 312.5 lines on average. A 2-bit code tells the analog bias driver which of three substrate levels to apply.

Top module: `shutter_timing_gen`

## Requirements
- R1: While rst_ni is low with hsync_i, vsync_i and hblank_i low, read_pulse_o and discard_o are 0 and bias_code_o is 00.
- R2: A vsync_i pulse sets the line index to 0 and an hsync_i pulse without vsync_i adds one to it. read_pulse_o is 1 from the cycle after a vsync_i pulse until the cycle after the next hsync_i pulse, that is, for the whole of line 0.
- R3: Fields after reset use FIELD_LINES_A lines, then FIELD_LINES_B, and keep alternating. In each field the threshold is the field length minus the clamped storage setting N.
- R4: discard_o can be 1 only in lines whose index L meets 1 <= L < threshold, and only while hblank_i is 1.
- R5: Inside one blanking interval, with k counting cycles from 0 at the first cycle where hblank_i is 1, discard_o follows the chop pattern: it is 1 when k mod (CHOP_ON+CHOP_OFF) < CHOP_ON. So each blanking interval holds a burst of pulses of CHOP_ON cycles.
- R6: A setting of 0 counts as N=1, and a setting above the field length counts as the field length. N equal to the field length gives no discard pulse in that field.
- R7: store_lines_i is sampled only in a cycle where vsync_i is 1. Changes at any other time have no effect on the discard pattern of the current field.
- R8: In line 0, the read line, discard_o stays 0 even during blanking.
- R9: bias_code_o is 10 (highest level) while discard_o is 1. Otherwise it is 01 while hblank_i is 1 and 00 when it is not. The value 11 never appears.
- R10: After reset and before the first vsync_i pulse, read_pulse_o and discard_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | One-cycle line start pulse |
| vsync_i | input | 1 | One-cycle field start pulse, marks line 0 |
| hblank_i | input | 1 | High during horizontal blanking |
| store_lines_i | input | LINE_W | Storage time in lines, sampled at vsync_i |
| read_pulse_o | output | 1 | High for the read line of each field |
| discard_o | output | 1 | Charge discard pulse |
| bias_code_o | output | 2 | Substrate level: 00 low, 01 middle, 10 discard |

## Verification
The assertions assume that hsync_i and vsync_i are single-cycle pulses and that a vsync_i pulse takes the place of the hsync_i pulse of line 0. They also assume that the upstream timing really delivers fields of the alternating lengths, because the threshold check and the line counter both rely on that order. The bench builds every field from fixed line templates: one sync pulse in the first cycle of each line, then a fixed blanking window. It drives exactly the field length expected for the current parity. It sweeps every storage setting a 3-bit input can carry over both field lengths, and it changes the setting on every line to check that mid-field changes are ignored.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  typedef enum logic [1:0] {
    BIAS_LOW  = 2'b00,
    BIAS_MID  = 2'b01,
    BIAS_DUMP = 2'b10
  } bias_e;
endpackage

// File: rtl/line_tracker.sv
module line_tracker #(
  parameter int LINE_W = 9,
  parameter int LEN_A  = 312,
  parameter int LEN_B  = 313
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] next_len_o,
  output logic              run_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q;
  logic              par_q;
  logic              run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      par_q  <= 1'b1;
      run_q  <= 1'b0;
    end else if (vsync_i) begin
      line_q <= '0;
      par_q  <= ~par_q;
      run_q  <= 1'b1;
    end else if (hsync_i && line_q != LINE_MAX) begin
      line_q <= line_q + 1'b1;
    end
  end

  // length of the field that the next vsync opens
  assign next_len_o = par_q ? LINE_W'(LEN_A) : LINE_W'(LEN_B);
  assign line_o     = line_q;
  assign run_o      = run_q;

  AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> line_q == '0); // R2
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vsync_i && !hsync_i) |=> $stable(line_q)); // R2
  AST_FIELD_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> next_len_o != $past(next_len_o)); // R3
endmodule

// File: rtl/exposure_latch.sv
module exposure_latch #(
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic [LINE_W-1:0] store_i,
  input  logic [LINE_W-1:0] len_i,
  output logic [LINE_W-1:0] thr_o
);
  logic [LINE_W-1:0] n_clamped;
  logic [LINE_W-1:0] thr_q;

  always_comb begin
    if (store_i == '0)       n_clamped = LINE_W'(1);
    else if (store_i > len_i) n_clamped = len_i;
    else                     n_clamped = store_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      thr_q <= '0;
    else if (vsync_i) thr_q <= len_i - n_clamped;
  end

  assign thr_o = thr_q;

  AST_HOLD_SETTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(thr_q)); // R7
  AST_THR_BELOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> thr_q < $past(len_i)); // R6
endmodule

// File: rtl/discard_chopper.sv
module discard_chopper #(
  parameter int LINE_W   = 9,
  parameter int CHOP_ON  = 2,
  parameter int CHOP_OFF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hblank_i,
  input  logic              run_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] thr_i,
  output logic              discard_o
);
  localparam int PERIOD = CHOP_ON + CHOP_OFF;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] ON_C    = CW'(CHOP_ON);
  localparam logic [CW-1:0] ON_LAST = CW'(CHOP_ON - 1);

  logic [CW-1:0] chop_q;
  logic          line_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 chop_q <= '0;
    else if (!hblank_i)          chop_q <= '0;
    else if (chop_q == LAST)     chop_q <= '0;
    else                         chop_q <= chop_q + 1'b1;
  end

  // line 0 carries the read pulse, so it never discards
  assign line_ok   = run_i && (line_i != '0) && (line_i < thr_i);
  assign discard_o = hblank_i && line_ok && (chop_q < ON_C);

  AST_CHOP_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_o && chop_q == ON_LAST) |=> !discard_o); // R5
endmodule

// File: rtl/shutter_timing_gen.sv
module shutter_timing_gen #(
  parameter int FIELD_LINES_A = 312,
  parameter int FIELD_LINES_B = 313,
  parameter int CHOP_ON       = 2,
  parameter int CHOP_OFF      = 2,
  localparam int LEN_MAX = (FIELD_LINES_A > FIELD_LINES_B) ? FIELD_LINES_A : FIELD_LINES_B,
  localparam int LINE_W  = $clog2(LEN_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              hblank_i,
  input  logic [LINE_W-1:0] store_lines_i,
  output logic              read_pulse_o,
  output logic              discard_o,
  output logic [1:0]        bias_code_o
);
  import shutter_pkg::*;

  logic [LINE_W-1:0] line_idx;
  logic [LINE_W-1:0] next_len;
  logic [LINE_W-1:0] thr;
  logic              run;
  logic              disc;
  bias_e             bias;

  line_tracker #(
    .LINE_W(LINE_W), .LEN_A(FIELD_LINES_A), .LEN_B(FIELD_LINES_B)
  ) u_lines (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .line_o(line_idx), .next_len_o(next_len), .run_o(run)
  );

  exposure_latch #(.LINE_W(LINE_W)) u_expo (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_i(vsync_i),
    .store_i(store_lines_i), .len_i(next_len), .thr_o(thr)
  );

  discard_chopper #(
    .LINE_W(LINE_W), .CHOP_ON(CHOP_ON), .CHOP_OFF(CHOP_OFF)
  ) u_chop (
    .clk_i(clk_i), .rst_ni(rst_ni), .hblank_i(hblank_i), .run_i(run),
    .line_i(line_idx), .thr_i(thr), .discard_o(disc)
  );

  always_comb begin
    if (disc)          bias = BIAS_DUMP;
    else if (hblank_i) bias = BIAS_MID;
    else               bias = BIAS_LOW;
  end

  assign read_pulse_o = run && (line_idx == '0);
  assign discard_o    = disc;
  assign bias_code_o  = bias;

  AST_DISCARD_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> hblank_i); // R4
  AST_NO_DISCARD_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> !read_pulse_o); // R8
  AST_BIAS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_code_o != 2'b11); // R9
  AST_READ_AFTER_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> read_pulse_o); // R2
endmodule

// File: tb/shutter_timing_gen_tb_top.sv
module shutter_timing_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int LA = 6;
  localparam int LB = 7;
  localparam int ON = 2;
  localparam int OFF = 1;
  localparam int P = ON + OFF;
  localparam int LW = 3;
  localparam int LINE_CYC = 10;
  localparam int BLK = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, hb = 1'b0;
  logic [LW-1:0] st = '0;
  logic rd, dc;
  logic [1:0] bc;

  int total = 0;
  int bad = 0;

  // bench model state
  int m_line = 0, m_run = 0, m_par = 1, m_thr = 0, m_chop = 0, m_len = 0, m_n = 0;
  int pulses = 0;
  logic prev_dc = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  shutter_timing_gen #(
    .FIELD_LINES_A(LA), .FIELD_LINES_B(LB), .CHOP_ON(ON), .CHOP_OFF(OFF)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs), .hblank_i(hb),
    .store_lines_i(st), .read_pulse_o(rd), .discard_o(dc), .bias_code_o(bc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic h, input logic v, input logic b, input logic [LW-1:0] s);
    logic e_rd, e_dc, line_ok;
    int e_bc;
    string tag;
    @(negedge clk);
    hs = h; vs = v; hb = b; st = s;
    #1;
    line_ok = (m_run != 0) && (m_line != 0) && (m_line < m_thr);
    e_rd = (m_run != 0) && (m_line == 0);
    e_dc = b && line_ok && (m_chop < ON);
    e_bc = e_dc ? 2 : (b ? 1 : 0);
    if (m_run == 0) tag = "R10";
    else if (m_line == 0) tag = "R8";
    else if (b && line_ok && m_chop >= ON) tag = "R5";
    else tag = "R4";
    chk((m_run == 0) ? "R10" : "R2", "read_pulse", rd, e_rd);
    chk(tag, "discard", dc, e_dc);
    chk("R9", "bias_code", bc, e_bc);
    if (dc && !prev_dc) pulses++;
    prev_dc = dc;
    // model advances as the next edge would
    if (v) begin
      if (m_run != 0) begin
        int lines_on;
        lines_on = m_len - m_n - 1;
        if (lines_on < 0) lines_on = 0;
        chk((m_n == m_len) ? "R6" : "R3", "field discard pulses", pulses,
            lines_on * ((BLK + P - 1) / P));
      end
      pulses = 0;
      m_par ^= 1;
      m_len = (m_par == 0) ? LA : LB;
      m_n = (s == 0) ? 1 : ((int'(s) > m_len) ? m_len : int'(s));
      m_thr = m_len - m_n;
      m_line = 0;
      m_run = 1;
    end else if (h) begin
      m_line++;
    end
    m_chop = b ? ((m_chop == P - 1) ? 0 : m_chop + 1) : 0;
  endtask

  task automatic line(input logic first, input logic use_vs, input logic [LW-1:0] s0,
                      input logic [LW-1:0] s1);
    for (int c = 0; c < LINE_CYC; c++) begin
      logic b;
      b = (c >= 1) && (c <= BLK);
      cycle(c == 0 && !use_vs && first, c == 0 && use_vs, b, (c == 0) ? s0 : s1);
    end
  endtask

  initial begin
    int dpar;
    #(CLK_P * 200000);
    $display("FAIL R2 watchdog act=hung exp=finished");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
    dpar = 0;
  end

  initial begin
    int dpar;
    dpar = 1;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R1", "read_pulse in reset", rd, 0);
      chk("R1", "discard in reset", dc, 0);
      chk("R1", "bias in reset", bc, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R10: lines before the first field start
    for (int l = 0; l < 3; l++) line(1'b1, 1'b0, 3'd2, 3'd2);
    // R3 R6 R7: sweep every setting over both field lengths
    for (int n = 0; n < 8; n++) begin
      for (int f = 0; f < 2; f++) begin
        int len;
        dpar ^= 1;
        len = (dpar == 0) ? LA : LB;
        line(1'b1, 1'b1, LW'(n), LW'(n * 5 + 3));
        for (int l = 1; l < len; l++)
          line(1'b1, 1'b0, LW'(n * 3 + l), LW'(l + 1));  // R7 mid-field churn
      end
    end
    line(1'b1, 1'b1, 3'd1, 3'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule